// File: doc/BRIEF.md
# Pointer Address-Load Execution Unit

This unit carries out the four instructions of an 8-bit accumulator CPU that load a computed address into one of the 16-bit pointer registers (X, Y, U, S). The surrounding core presents the opcode byte, the indexed-mode postbyte, the program counter, the four pointer values and the current zero flag, then pulses `start`. The unit works out the effective address and applies any automatic pointer adjustment. For the indirect forms it fetches a 16-bit word, one byte at a time, over a request/valid read port. It then returns the new register set, zero flag and program counter, all valid in the single cycle that `done` is high.

The unit matches the silicon's known quirks, which software relies on. When the destination register is also the base register of a post-increment, the destination write wins, so the register keeps its old value. Only the X and Y destinations change the zero flag. The one-step indirect auto modes `[,R+]` and `[,-R]` run normally and do not trap.

Top module: `lea_exec_unit`

## Requirements
- R1: Opcode 0x30 writes X, 0x31 writes Y, 0x32 writes S and 0x33 writes U. Every supported form returns `pc_out` equal to `pc_in` + 2.
- R2: With postbyte bit 7 clear, the address is the base register selected by bits 6:5 plus the signed 5-bit offset in bits 4:0. No indirection and no pointer change take place.
- R3: With postbyte bit 7 set, bits 6:5 pick the base (00 X, 01 Y, 10 U, 11 S) and bit 4 selects indirection. Bits 3:0 pick the mode: 0000 post-increment 1, 0001 post-increment 2, 0010 pre-decrement 1, 0011 pre-decrement 2, 0100 no change.
- R4: A pre-decrement subtracts 1 or 2 from the base and uses that value as the address. A post-increment uses the unmodified base as the address and then adds 1 or 2 to the base register.
- R5: When the destination is the same register as the auto-modified base, the destination value overrides the adjustment. This holds for all four pointers and for both direct and indirect forms.
- R6: X and Y destinations set Z when the 16-bit result is zero and clear it otherwise. U and S destinations return Z unchanged.
- R7: An indirect form reads the high byte at the effective address and then the low byte at the address plus one. Each request holds `mem_req` and `mem_addr` steady until `mem_valid` is seen. The result is the high byte followed by the low byte.
- R8: The indirect forms with a single-step increment or decrement execute like any other indirect form, with `unsupported` low.
- R9: An opcode outside 0x30..0x33, or a bit-7-set mode code above 0100, completes with `unsupported` high. The outputs then return the input register values, Z and PC unchanged, and no memory read is issued.
- R10: `done` is high for exactly one cycle per accepted `start`. A `start` seen while an operation is in progress is ignored, and so is any change to the other inputs during that time.
- R11: After reset, `done`, `mem_req` and `unsupported` are low, and all register outputs and Z are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction; taken only when idle |
| opcode | input | 8 | Instruction opcode byte |
| postbyte | input | 8 | Indexed addressing postbyte |
| pc_in | input | W | Address of the opcode |
| x_in | input | W | Current X |
| y_in | input | W | Current Y |
| u_in | input | W | Current U |
| s_in | input | W | Current S |
| z_in | input | 1 | Current zero flag |
| mem_req | output | 1 | Byte read request, held until valid |
| mem_addr | output | W | Byte read address |
| mem_valid | input | 1 | Read data present this cycle |
| mem_rdata | input | W/2 | Read data byte |
| done | output | 1 | One-cycle completion pulse |
| unsupported | output | 1 | Form not handled; registers unchanged |
| pc_out | output | W | Next PC |
| x_out | output | W | New X |
| y_out | output | W | New Y |
| u_out | output | W | New U |
| s_out | output | W | New S |
| z_out | output | 1 | New zero flag |

## Verification
The bench targets same-register post-increment on every pointer, direct and indirect. A design that let the adjustment win would return the base plus 1 or 2 instead of the original value or the fetched word. It checks Z on U/S destinations with a zero result, where a flag that is wrongly written would flip. It checks pre-decrement addressing, where using the old base would fetch the wrong bytes, and byte order, where swapped reads would show as a reversed word. The one-step indirect modes are run to catch a design that flags them as unsupported. A second `start` during a slow memory read must be ignored; otherwise the results would be corrupted.

// File: rtl/lea_pkg.sv
package lea_pkg;

    parameter int unsigned PTR_W = 16;

    localparam logic [7:0] OP_LOAD_X = 8'h30;
    localparam logic [7:0] OP_LOAD_Y = 8'h31;
    localparam logic [7:0] OP_LOAD_S = 8'h32;
    localparam logic [7:0] OP_LOAD_U = 8'h33;

    typedef enum logic [1:0] {
        PTR_X = 2'd0,
        PTR_Y = 2'd1,
        PTR_U = 2'd2,
        PTR_S = 2'd3
    } ptr_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RD_HI = 2'd1,
        PH_RD_LO = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

    typedef struct packed {
        logic              ok;
        ptr_e              dst;
        ptr_e              base;
        logic              indirect;
        logic              pre;
        logic signed [2:0] step;
        logic              use_off;
        logic        [4:0] off;
    } lea_dec_t;

endpackage

// File: rtl/lea_decode.sv
module lea_decode
    import lea_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [7:0] postbyte,
    output lea_dec_t   dec
);
    logic op_ok;
    logic mode_ok;

    always_comb begin
        dec      = '0;
        op_ok    = 1'b1;
        mode_ok  = 1'b1;
        unique case (opcode)
            OP_LOAD_X: dec.dst = PTR_X;
            OP_LOAD_Y: dec.dst = PTR_Y;
            OP_LOAD_S: dec.dst = PTR_S;
            OP_LOAD_U: dec.dst = PTR_U;
            default:   op_ok   = 1'b0;
        endcase
        dec.base = ptr_e'(postbyte[6:5]);
        if (!postbyte[7]) begin
            dec.use_off = 1'b1;
            dec.off     = postbyte[4:0];
        end else begin
            dec.indirect = postbyte[4];
            case (postbyte[3:0])
                4'b0000: dec.step = 3'sd1;
                4'b0001: dec.step = 3'sd2;
                4'b0010: begin dec.step = -3'sd1; dec.pre = 1'b1; end
                4'b0011: begin dec.step = -3'sd2; dec.pre = 1'b1; end
                4'b0100: dec.step = 3'sd0;
                default: mode_ok  = 1'b0;
            endcase
        end
        dec.ok = op_ok && mode_ok;
    end
endmodule

// File: rtl/lea_addr.sv
module lea_addr #(
    parameter int unsigned W = 16
) (
    input  logic              [W-1:0] base_val,
    input  logic                      pre,
    input  logic signed       [2:0]   step,
    input  logic                      use_off,
    input  logic              [4:0]   off,
    output logic              [W-1:0] ea,
    output logic              [W-1:0] base_new
);
    logic [W-1:0] step_ext;
    logic [W-1:0] off_ext;

    always_comb begin
        step_ext = {{(W-3){step[2]}}, step};
        off_ext  = {{(W-5){off[4]}}, off};
        base_new = base_val + step_ext;
        if (pre) begin
            ea = base_new;
        end else if (use_off) begin
            ea = base_val + off_ext;
        end else begin
            ea = base_val;
        end
    end
endmodule

// File: rtl/lea_writeback.sv
module lea_writeback
    import lea_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [3:0][W-1:0] regs_in,
    input  logic              z_in,
    input  logic              base_en,
    input  ptr_e              base_sel,
    input  logic [W-1:0]      base_val,
    input  logic              dst_en,
    input  ptr_e              dst_sel,
    input  logic [W-1:0]      dst_val,
    output logic [3:0][W-1:0] regs_out,
    output logic              z_out
);
    for (genvar g = 0; g < 4; g++) begin : g_reg
        always_comb begin
            if (dst_en && (dst_sel == ptr_e'(g))) begin
                regs_out[g] = dst_val;
            end else if (base_en && (base_sel == ptr_e'(g))) begin
                regs_out[g] = base_val;
            end else begin
                regs_out[g] = regs_in[g];
            end
        end
    end

    always_comb begin
        if (dst_en && (dst_sel == PTR_X || dst_sel == PTR_Y)) begin
            z_out = (dst_val == '0);
        end else begin
            z_out = z_in;
        end
    end
endmodule

// File: rtl/lea_exec_unit.sv
module lea_exec_unit
    import lea_pkg::*;
#(
    parameter  int unsigned W  = PTR_W,
    localparam int unsigned BW = W / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    opcode,
    input  logic [7:0]    postbyte,
    input  logic [W-1:0]  pc_in,
    input  logic [W-1:0]  x_in,
    input  logic [W-1:0]  y_in,
    input  logic [W-1:0]  u_in,
    input  logic [W-1:0]  s_in,
    input  logic          z_in,
    output logic          mem_req,
    output logic [W-1:0]  mem_addr,
    input  logic          mem_valid,
    input  logic [BW-1:0] mem_rdata,
    output logic          done,
    output logic          unsupported,
    output logic [W-1:0]  pc_out,
    output logic [W-1:0]  x_out,
    output logic [W-1:0]  y_out,
    output logic [W-1:0]  u_out,
    output logic [W-1:0]  s_out,
    output logic          z_out
);
    localparam logic [W-1:0] PC_STEP = W'(2);

    typedef struct packed {
        phase_e            ph;
        logic [3:0][W-1:0] regs;
        logic [W-1:0]      pc;
        logic              z;
        logic [W-1:0]      ea;
        ptr_e              dst;
        logic [BW-1:0]     hi;
        logic              unsup;
    } state_t;

    state_t st_d, st_q;

    lea_dec_t          dec;
    logic [3:0][W-1:0] in_regs;
    logic [W-1:0]      ea, base_new;
    logic [3:0][W-1:0] wb_regs_in, wb_regs_out;
    logic              wb_z_in, wb_z_out;
    logic              wb_base_en, wb_dst_en;
    ptr_e              wb_dst;
    logic [W-1:0]      wb_dst_val;

    assign in_regs = {s_in, u_in, y_in, x_in};

    lea_decode u_decode (
        .opcode   (opcode),
        .postbyte (postbyte),
        .dec      (dec)
    );

    lea_addr #(.W(W)) u_addr (
        .base_val (in_regs[dec.base]),
        .pre      (dec.pre),
        .step     (dec.step),
        .use_off  (dec.use_off),
        .off      (dec.off),
        .ea       (ea),
        .base_new (base_new)
    );

    lea_writeback #(.W(W)) u_wb (
        .regs_in  (wb_regs_in),
        .z_in     (wb_z_in),
        .base_en  (wb_base_en),
        .base_sel (dec.base),
        .base_val (base_new),
        .dst_en   (wb_dst_en),
        .dst_sel  (wb_dst),
        .dst_val  (wb_dst_val),
        .regs_out (wb_regs_out),
        .z_out    (wb_z_out)
    );

    always_comb begin
        st_d       = st_q;
        wb_regs_in = (st_q.ph == PH_IDLE) ? in_regs : st_q.regs;
        wb_z_in    = (st_q.ph == PH_IDLE) ? z_in : st_q.z;
        wb_dst     = (st_q.ph == PH_IDLE) ? dec.dst : st_q.dst;
        wb_base_en = 1'b0;
        wb_dst_en  = 1'b0;
        wb_dst_val = ea;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.unsup = !dec.ok;
                    st_d.dst   = dec.dst;
                    st_d.ea    = ea;
                    if (dec.ok) begin
                        wb_base_en = 1'b1;
                        wb_dst_en  = !dec.indirect;
                        st_d.regs  = wb_regs_out;
                        st_d.z     = wb_z_out;
                        st_d.pc    = dec.indirect ? pc_in : pc_in + PC_STEP;
                        st_d.ph    = dec.indirect ? PH_RD_HI : PH_DONE;
                    end else begin
                        st_d.regs  = in_regs;
                        st_d.z     = z_in;
                        st_d.pc    = pc_in;
                        st_d.ph    = PH_DONE;
                    end
                end
            end
            PH_RD_HI: begin
                if (mem_valid) begin
                    st_d.hi = mem_rdata;
                    st_d.ph = PH_RD_LO;
                end
            end
            PH_RD_LO: begin
                wb_dst_val = {st_q.hi, mem_rdata};
                if (mem_valid) begin
                    wb_dst_en = 1'b1;
                    st_d.regs = wb_regs_out;
                    st_d.z    = wb_z_out;
                    st_d.pc   = st_q.pc + PC_STEP;
                    st_d.ph   = PH_DONE;
                end
            end
            PH_DONE: st_d.ph = PH_IDLE;
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_req     = (st_q.ph == PH_RD_HI) || (st_q.ph == PH_RD_LO);
    assign mem_addr    = (st_q.ph == PH_RD_LO) ? st_q.ea + W'(1) : st_q.ea;
    assign done        = (st_q.ph == PH_DONE);
    assign unsupported = st_q.unsup;
    assign pc_out      = st_q.pc;
    assign x_out       = st_q.regs[PTR_X];
    assign y_out       = st_q.regs[PTR_Y];
    assign u_out       = st_q.regs[PTR_U];
    assign s_out       = st_q.regs[PTR_S];
    assign z_out       = st_q.z;

    // Observation state for the assertions below
    logic [1:0] chk_reads_q;
    logic [7:0] chk_op_q;
    logic       chk_z_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_reads_q <= '0;
            chk_op_q    <= '0;
            chk_z_q     <= 1'b0;
        end else if (st_q.ph == PH_IDLE && start) begin
            chk_reads_q <= '0;
            chk_op_q    <= opcode;
            chk_z_q     <= z_in;
        end else if (mem_req && mem_valid) begin
            chk_reads_q <= chk_reads_q + 2'd1;
        end
    end

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    p_low_byte_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid && chk_reads_q == 2'd0)
            |=> (mem_req && mem_addr == $past(mem_addr) + W'(1)));

    p_read_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (chk_reads_q == 2'd0 || chk_reads_q == 2'd2));

    p_unsup_no_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && unsupported) |-> (chk_reads_q == 2'd0));

    p_us_keep_z_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !unsupported && (chk_op_q == OP_LOAD_U || chk_op_q == OP_LOAD_S))
            |-> (z_out == chk_z_q));

endmodule

// File: tb/lea_exec_unit_bench.sv
`timescale 1ns/1ps
module lea_exec_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0, postbyte = '0;
    logic [15:0] pc_in = '0, x_in = '0, y_in = '0, u_in = '0, s_in = '0;
    logic        z_in = 1'b0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        done, unsupported, z_out;
    logic [15:0] pc_out, x_out, y_out, u_out, s_out;

    int errors = 0;
    int checks = 0;
    int mem_lat = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lea_exec_unit u_lea_exec_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .postbyte(postbyte),
        .pc_in(pc_in), .x_in(x_in), .y_in(y_in), .u_in(u_in), .s_in(s_in), .z_in(z_in),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .done(done), .unsupported(unsupported), .pc_out(pc_out),
        .x_out(x_out), .y_out(y_out), .u_out(u_out), .s_out(s_out), .z_out(z_out)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        if (a == 16'hEC00) return 8'h80;
        if (a == 16'hEC01) return 8'h00;
        return a[7:0] ^ 8'h5A;
    endfunction

    // Memory responder: answers after mem_lat idle cycles with a one-cycle valid
    initial begin
        int wait_n = 0;
        forever begin
            @(negedge clk);
            if (mem_valid) begin
                mem_valid = 1'b0;
            end else if (mem_req) begin
                if (wait_n >= mem_lat) begin
                    mem_valid = 1'b1;
                    mem_rdata = mem_byte(mem_addr);
                    wait_n    = 0;
                end else begin
                    wait_n++;
                end
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Row: op, pb, x, y, u, s, zin, ex, ey, eu, es, ez, eunsup
    localparam int NV = 20;
    localparam int VW = 147;
    localparam logic [VW-1:0] VEC [NV] = '{
        {8'h30,8'h84,16'h2000,16'h3000,16'h4000,16'h5000,1'b1,16'h2000,16'h3000,16'h4000,16'h5000,1'b0,1'b0},
        {8'h30,8'h80,16'h2000,16'h3000,16'h4000,16'h5000,1'b1,16'h2000,16'h3000,16'h4000,16'h5000,1'b0,1'b0},
        {8'h31,8'h81,16'h2000,16'h3000,16'h4000,16'h5000,1'b1,16'h2002,16'h2000,16'h4000,16'h5000,1'b0,1'b0},
        {8'h33,8'hC0,16'h2000,16'h3000,16'h4000,16'h5000,1'b1,16'h2000,16'h3000,16'h4000,16'h5000,1'b1,1'b0},
        {8'h32,8'hE1,16'h2000,16'h3000,16'h4000,16'h5000,1'b1,16'h2000,16'h3000,16'h4000,16'h5000,1'b1,1'b0},
        {8'h31,8'hA1,16'h2000,16'h3000,16'h4000,16'h5000,1'b1,16'h2000,16'h3000,16'h4000,16'h5000,1'b0,1'b0},
        {8'h32,8'h82,16'h2000,16'h3000,16'h4000,16'h5000,1'b1,16'h1FFF,16'h3000,16'h4000,16'h1FFF,1'b1,1'b0},
        {8'h30,8'hA3,16'h2000,16'h3000,16'h4000,16'h5000,1'b1,16'h2FFE,16'h2FFE,16'h4000,16'h5000,1'b0,1'b0},
        {8'h30,8'h1F,16'h2000,16'h3000,16'h4000,16'h5000,1'b1,16'h1FFF,16'h3000,16'h4000,16'h5000,1'b0,1'b0},
        {8'h30,8'h2F,16'h2000,16'h3000,16'h4000,16'h5000,1'b1,16'h300F,16'h3000,16'h4000,16'h5000,1'b0,1'b0},
        {8'h31,8'h84,16'h0000,16'h3000,16'h4000,16'h5000,1'b0,16'h0000,16'h0000,16'h4000,16'h5000,1'b1,1'b0},
        {8'h33,8'h84,16'h0000,16'h3000,16'h4000,16'h5000,1'b0,16'h0000,16'h3000,16'h0000,16'h5000,1'b0,1'b0},
        {8'h33,8'h90,16'hEC00,16'h3000,16'h4000,16'h5000,1'b1,16'hEC01,16'h3000,16'h8000,16'h5000,1'b1,1'b0},
        {8'h30,8'hF3,16'h2000,16'h3000,16'h4000,16'h5000,1'b1,16'hA4A5,16'h3000,16'h4000,16'h4FFE,1'b0,1'b0},
        {8'h31,8'hB4,16'h2000,16'h3000,16'h4000,16'h5000,1'b1,16'h2000,16'h5A5B,16'h4000,16'h5000,1'b0,1'b0},
        {8'h30,8'h91,16'h2000,16'h3000,16'h4000,16'h5000,1'b1,16'h5A5B,16'h3000,16'h4000,16'h5000,1'b0,1'b0},
        {8'h32,8'hD2,16'h2000,16'h3000,16'h4000,16'h5000,1'b1,16'h2000,16'h3000,16'h3FFF,16'hA55A,1'b1,1'b0},
        {8'h30,8'h85,16'h2000,16'h3000,16'h4000,16'h5000,1'b1,16'h2000,16'h3000,16'h4000,16'h5000,1'b1,1'b1},
        {8'h34,8'h84,16'h2000,16'h3000,16'h4000,16'h5000,1'b1,16'h2000,16'h3000,16'h4000,16'h5000,1'b1,1'b1},
        {8'h30,8'h9F,16'h2000,16'h3000,16'h4000,16'h5000,1'b0,16'h2000,16'h3000,16'h4000,16'h5000,1'b0,1'b1}
    };

    function automatic string row_tag(input int i);
        case (i)
            0:           return "R1 R3";
            1, 3, 4, 5:  return "R5";
            2, 6, 7:     return "R4";
            8, 9:        return "R2";
            10, 11:      return "R6";
            12:          return "R8";
            13, 14, 16:  return "R7";
            15:          return "R5 R7";
            default:     return "R9";
        endcase
    endfunction

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        checks++;
        if (!done) begin
            errors++;
            $display("FAIL %s done: actual=0 expected=1", tag);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "done", {15'd0, done}, 16'd0);
        chk("R11", "mem_req", {15'd0, mem_req}, 16'd0);
        chk("R11", "unsupported", {15'd0, unsupported}, 16'd0);
        chk("R11", "x_out", x_out, 16'h0000);
        chk("R11", "s_out", s_out, 16'h0000);
        chk("R11", "z_out", {15'd0, z_out}, 16'd0);
        rst_n = 1'b1;
        pc_in = 16'hEB00;

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            string tg;
            v       = VEC[i];
            tg      = row_tag(i);
            mem_lat = i % 3;
            @(negedge clk);
            opcode = v[146:139]; postbyte = v[138:131];
            x_in = v[130:115]; y_in = v[114:99]; u_in = v[98:83]; s_in = v[82:67];
            z_in = v[66];
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done(tg);
            chk(tg, "x_out", x_out, v[65:50]);
            chk(tg, "y_out", y_out, v[49:34]);
            chk(tg, "u_out", u_out, v[33:18]);
            chk(tg, "s_out", s_out, v[17:2]);
            chk(tg, "z_out", {15'd0, z_out}, {15'd0, v[1]});
            chk(tg, "unsupported", {15'd0, unsupported}, {15'd0, v[0]});
            chk(tg, "pc_out", pc_out, v[0] ? 16'hEB00 : 16'hEB02);
        end

        // R10: a start during a slow indirect read is ignored
        mem_lat = 4;
        @(negedge clk);
        opcode = 8'h33; postbyte = 8'h90;
        x_in = 16'hEC00; y_in = 16'h3000; u_in = 16'h4000; s_in = 16'h5000; z_in = 1'b0;
        start = 1'b1;
        @(negedge clk);
        opcode = 8'h30; postbyte = 8'h84; x_in = 16'h0000;
        while (!done) @(negedge clk);
        start = 1'b0;
        chk("R10", "x_out busy", x_out, 16'hEC01);
        chk("R10", "u_out busy", u_out, 16'h8000);
        chk("R10", "z_out busy", {15'd0, z_out}, 16'd0);
        @(negedge clk);
        chk("R10", "done pulse width", {15'd0, done}, 16'd0);
        chk("R10", "mem_req after done", {15'd0, mem_req}, 16'd0);
        @(negedge clk);
        chk("R10", "no second done", {15'd0, done}, 16'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule